// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one machine cycle at a time on a bus where address and data take turns on the same wires. A request names the cycle kind: internal, instruction fetch, memory operand transfer or I/O transfer. Transfers also carry a direction. The sequencer then steps through an address phase and a data phase, timed by the oscillator clock. It drives the address strobe, the data strobe, the read-direction strobe, the cycle-type lines and an internal sync phase. It also drives the shared bus output and its enable.

Every transfer lasts at least five clocks. External memory stretches it by holding the active-low ready input high during the last phase. On a read, the bus value is loaded into a data-input register at the clock edge where the sync phase falls and the cycle ends. One clock later, a one-clock completion pulse tells the pipeline or execute logic that it may start the next cycle.

A request is taken only while the block is idle. The address and write data are latched when the request is taken, so the registers that feed them may change during the cycle.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset, sync_n is 0, as_o is 0, ds_n and dd_n are 1, ad_oe is 0, rd_wn is 1, in_opn is 0, m_ion is 1, busy and cyc_done are 0, and din_reg is 0.
- R2: An internal cycle (cyc_kind 2'b00) lasts 5 clocks, or 6 clocks when int_long is 1. During it, as_o is 0, ds_n, dd_n and m_ion are 1, and the bus is not driven. rdy_n has no effect on it.
- R3: The cycle-type lines are set from the kind code. Fetch (2'b01) sets in_opn=1 and m_ion=1. Memory (2'b10) sets in_opn=0 and m_ion=1. I/O (2'b11) sets in_opn=0 and m_ion=0. rd_wn is 0 only for a memory or I/O cycle requested with wr=1. A fetch is always a read.
- R4: In the first two clocks of a transfer, sync_n is 0 and ad_out carries the latched address with ad_oe=1. as_o is 1 in the second clock only.
- R5: On a write, sync_n goes to 1 from the third clock on, and ad_out carries the latched write data with ad_oe=1 until the cycle ends. ds_n is 0 from the fourth clock to the end. dd_n stays 1 for the whole cycle.
- R6: On a read, ad_oe is 0 from the third clock on. ds_n is 0 from the fourth clock and dd_n is 0 from the fifth clock. Both return to 1, with ad_oe at 0, in the clock after the cycle ends.
- R7: A transfer lasts 5 clocks plus one clock for every rising clock edge in the last phase at which rdy_n is sampled 1.
- R8: din_reg loads ad_in at the edge that ends a read cycle, when sync_n falls. Writes and internal cycles leave din_reg unchanged.
- R9: busy is 1 for every clock of a cycle. cyc_done is 1 for exactly one clock, the clock after the cycle ends.
- R10: start while busy is ignored: the running cycle keeps its length, and no new cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Cycle request, taken when idle |
| cyc_kind | input | 2 | Cycle kind code |
| wr | input | 1 | Transfer direction, 1 = write |
| int_long | input | 1 | Selects the six-clock internal cycle |
| addr_reg | input | W | Address register |
| dout_reg | input | W | Data-output register |
| rdy_n | input | 1 | Active-low ready from memory |
| ad_in | input | W | Bus value seen from outside |
| ad_out | output | W | Bus output value |
| ad_oe | output | 1 | Bus output enable |
| sync_n | output | 1 | Internal sync phase |
| as_o | output | 1 | Address strobe |
| ds_n | output | 1 | Data strobe, active low |
| dd_n | output | 1 | Read-direction strobe, active low |
| rd_wn | output | 1 | 1 = read, 0 = write |
| in_opn | output | 1 | 1 = instruction fetch |
| m_ion | output | 1 | 1 = memory, 0 = I/O |
| din_reg | output | W | Data-input register |
| busy | output | 1 | Cycle in progress |
| cyc_done | output | 1 | One-clock completion pulse |

## Verification
The bench targets wait-state counting. A design that samples ready one phase early or late would make every stretched cycle one clock off. It compares the six-clock internal cycle with the five-clock one while ready stays high, which exposes a design that waits on ready during internal work. It checks that the bus is released in the third clock of reads and that write data replaces the address there, which catches a transceiver turnaround in the wrong phase. It also checks that the data-input register holds its value across writes, and that a start pulsed in mid-cycle queues nothing.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    CK_INTERNAL = 2'd0,
    CK_FETCH    = 2'd1,
    CK_MEM      = 2'd2,
    CK_IO       = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_ASTB = 3'd2,
    PH_TURN = 3'd3,
    PH_DSTB = 3'd4,
    PH_WAIT = 3'd5,
    PH_XTRA = 3'd6
  } phase_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      write;
    logic      stretch;
  } cyc_desc_t;

  function automatic logic is_xfer(cyc_desc_t d);
    return d.kind != CK_INTERNAL;
  endfunction

  function automatic logic is_read(cyc_desc_t d);
    return is_xfer(d) && !d.write;
  endfunction

  function automatic logic in_addr_phase(phase_e p);
    return (p == PH_ADDR) || (p == PH_ASTB);
  endfunction

endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic [1:0] kind_in,
  input  logic      write_in,
  input  logic      stretch_in,
  input  logic      rdy_n,
  output phase_e    ph_q,
  output phase_e    ph_d,
  output cyc_desc_t desc_q,
  output cyc_desc_t desc_d,
  output logic      accept,
  output logic      capture,
  output logic      done_q
);

  logic      finish;
  cyc_kind_e k_in;

  assign k_in = cyc_kind_e'(kind_in);

  always_comb begin
    ph_d   = ph_q;
    desc_d = desc_q;
    accept = 1'b0;
    finish = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          accept         = 1'b1;
          ph_d           = PH_ADDR;
          desc_d.kind    = k_in;
          desc_d.write   = write_in && (k_in == CK_MEM || k_in == CK_IO);
          desc_d.stretch = stretch_in && (k_in == CK_INTERNAL);
        end
      end
      PH_ADDR: ph_d = PH_ASTB;
      PH_ASTB: ph_d = PH_TURN;
      PH_TURN: ph_d = PH_DSTB;
      PH_DSTB: ph_d = PH_WAIT;
      PH_WAIT: begin
        if (!is_xfer(desc_q)) begin
          if (desc_q.stretch) ph_d = PH_XTRA;
          else                finish = 1'b1;
        end else if (!rdy_n) begin
          finish = 1'b1;
        end
      end
      PH_XTRA: finish = 1'b1;
      default: ph_d = PH_IDLE;
    endcase
    if (finish) ph_d = PH_IDLE;
  end

  assign capture = finish && is_read(desc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      desc_q <= '{kind: CK_INTERNAL, write: 1'b0, stretch: 1'b0};
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      desc_q <= desc_d;
      done_q <= finish;
    end
  end

endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
  import mbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  phase_e    ph_d,
  input  cyc_desc_t desc_d,
  output logic      sync_n,
  output logic      as_o,
  output logic      ds_n,
  output logic      dd_n,
  output logic      rd_wn,
  output logic      in_opn,
  output logic      m_ion
);

  logic xfer, rd, active;
  logic sync_n_d, as_d, ds_n_d, dd_n_d, rd_wn_d, in_opn_d, m_ion_d;

  assign xfer   = is_xfer(desc_d);
  assign rd     = is_read(desc_d);
  assign active = (ph_d != PH_IDLE);

  always_comb begin
    sync_n_d = !((ph_d == PH_IDLE) || in_addr_phase(ph_d));
    as_d     = xfer && (ph_d == PH_ASTB);
    ds_n_d   = !(xfer && (ph_d == PH_DSTB || ph_d == PH_WAIT));
    dd_n_d   = !(rd && (ph_d == PH_WAIT));
    rd_wn_d  = 1'b1;
    in_opn_d = 1'b0;
    m_ion_d  = 1'b1;
    if (active) begin
      rd_wn_d  = !desc_d.write;
      in_opn_d = (desc_d.kind == CK_FETCH);
      m_ion_d  = (desc_d.kind != CK_IO);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_n <= 1'b0;
      as_o   <= 1'b0;
      ds_n   <= 1'b1;
      dd_n   <= 1'b1;
      rd_wn  <= 1'b1;
      in_opn <= 1'b0;
      m_ion  <= 1'b1;
    end else begin
      sync_n <= sync_n_d;
      as_o   <= as_d;
      ds_n   <= ds_n_d;
      dd_n   <= dd_n_d;
      rd_wn  <= rd_wn_d;
      in_opn <= in_opn_d;
      m_ion  <= m_ion_d;
    end
  end

endmodule

// File: rtl/mbus_ad_path.sv
module mbus_ad_path
  import mbus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic         capture,
  input  phase_e       ph_d,
  input  cyc_desc_t    desc_d,
  input  logic [W-1:0] addr_in,
  input  logic [W-1:0] dout_in,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic [W-1:0] din_q
);

  logic [W-1:0] addr_q, dout_q, addr_src, dout_src, ad_d;
  logic         oe_d, addr_ph, data_ph;

  assign addr_src = accept ? addr_in : addr_q;
  assign dout_src = accept ? dout_in : dout_q;
  assign addr_ph  = in_addr_phase(ph_d);
  assign data_ph  = (ph_d == PH_TURN) || (ph_d == PH_DSTB) || (ph_d == PH_WAIT);

  always_comb begin
    oe_d = is_xfer(desc_d) && (addr_ph || (desc_d.write && data_ph));
    ad_d = addr_ph ? addr_src : dout_src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      dout_q <= '0;
      ad_out <= '0;
      ad_oe  <= 1'b0;
      din_q  <= '0;
    end else begin
      if (accept) begin
        addr_q <= addr_in;
        dout_q <= dout_in;
      end
      ad_out <= ad_d;
      ad_oe  <= oe_d;
      if (capture) din_q <= ad_in;
    end
  end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   cyc_kind,
  input  logic         wr,
  input  logic         int_long,
  input  logic [W-1:0] addr_reg,
  input  logic [W-1:0] dout_reg,
  input  logic         rdy_n,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         sync_n,
  output logic         as_o,
  output logic         ds_n,
  output logic         dd_n,
  output logic         rd_wn,
  output logic         in_opn,
  output logic         m_ion,
  output logic [W-1:0] din_reg,
  output logic         busy,
  output logic         cyc_done
);

  phase_e    ph_q, ph_d;
  cyc_desc_t desc_q, desc_d;
  logic      accept, capture;
  logic      cur_internal;

  mbus_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .kind_in(cyc_kind),
    .write_in(wr), .stretch_in(int_long), .rdy_n(rdy_n),
    .ph_q(ph_q), .ph_d(ph_d), .desc_q(desc_q), .desc_d(desc_d),
    .accept(accept), .capture(capture), .done_q(cyc_done)
  );

  mbus_strobe_gen u_stb (
    .clk(clk), .rst(rst), .ph_d(ph_d), .desc_d(desc_d),
    .sync_n(sync_n), .as_o(as_o), .ds_n(ds_n), .dd_n(dd_n),
    .rd_wn(rd_wn), .in_opn(in_opn), .m_ion(m_ion)
  );

  mbus_ad_path #(.W(W)) u_ad (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .ph_d(ph_d), .desc_d(desc_d), .addr_in(addr_reg), .dout_in(dout_reg),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .din_q(din_reg)
  );

  assign busy         = (ph_q != PH_IDLE);
  assign cur_internal = (desc_q.kind == CK_INTERNAL);

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ad_oe,
  input logic         sync_n,
  input logic         as_o,
  input logic         ds_n,
  input logic         dd_n,
  input logic         rd_wn,
  input logic         m_ion,
  input logic [W-1:0] din_reg,
  input logic         busy,
  input logic         cyc_done,
  input logic         cur_internal
);

  a_r2_internal_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_internal) |-> (!as_o && ds_n && dd_n && m_ion && !ad_oe));

  a_r4_as_single: assert property (@(posedge clk) disable iff (rst)
    as_o |=> !as_o);

  a_r4_as_in_sync_low: assert property (@(posedge clk) disable iff (rst)
    as_o |-> !sync_n);

  a_r5_write_dd_high: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_wn) |-> dd_n);

  a_r6_read_released: assert property (@(posedge clk) disable iff (rst)
    (!ds_n && rd_wn) |-> !ad_oe);

  a_r6_dd_inside_ds: assert property (@(posedge clk) disable iff (rst)
    !dd_n |-> !ds_n);

  a_r8_din_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(din_reg) |-> cyc_done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cyc_done);

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ad_oe(ad_oe), .sync_n(sync_n), .as_o(as_o),
  .ds_n(ds_n), .dd_n(dd_n), .rd_wn(rd_wn), .m_ion(m_ion),
  .din_reg(din_reg), .busy(busy), .cyc_done(cyc_done),
  .cur_internal(cur_internal)
);

// File: tb/sim_mbus_cycle_seq.sv
module sim_mbus_cycle_seq;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   cyc_kind = 2'd0;
  logic         wr = 1'b0;
  logic         int_long = 1'b0;
  logic [W-1:0] addr_reg = '0;
  logic [W-1:0] dout_reg = '0;
  logic         rdy_n = 1'b1;
  logic [W-1:0] ad_in = '0;
  logic [W-1:0] ad_out, din_reg;
  logic         ad_oe, sync_n, as_o, ds_n, dd_n, rd_wn, in_opn, m_ion, busy, cyc_done;

  mbus_cycle_seq #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .cyc_kind(cyc_kind), .wr(wr),
    .int_long(int_long), .addr_reg(addr_reg), .dout_reg(dout_reg),
    .rdy_n(rdy_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .sync_n(sync_n), .as_o(as_o), .ds_n(ds_n), .dd_n(dd_n), .rd_wn(rd_wn),
    .in_opn(in_opn), .m_ion(m_ion), .din_reg(din_reg), .busy(busy),
    .cyc_done(cyc_done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  typedef struct {
    int           len;
    logic [W-1:0] din;
  } exp_t;
  exp_t sb[$];
  logic [W-1:0] model_din = '0;
  int busy_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // scoreboard monitor: cycle length and data-input register
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_cnt++;
      if (cyc_done) begin
        if (sb.size() == 0) begin
          chk(0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(busy_cnt == e.len, "R7 cycle length", busy_cnt, e.len);
          chk(din_reg == e.din, "R8 din_reg", din_reg, e.din);
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic run_cycle(input logic [1:0] k, input logic w, input logic lng,
                           input logic [W-1:0] a, input logic [W-1:0] d,
                           input logic [W-1:0] rv, input int waits,
                           input bit poke);
    bit xfer, wre, rd;
    exp_t e;
    xfer = (k != 2'd0);
    wre  = w && (k == 2'd2 || k == 2'd3);
    rd   = xfer && !wre;
    e.len = xfer ? 5 + waits : (lng ? 6 : 5);
    if (rd) model_din = rv;
    e.din = model_din;
    sb.push_back(e);

    @(negedge clk);
    cyc_kind = k; wr = w; int_long = lng; addr_reg = a; dout_reg = d;
    ad_in = rv; rdy_n = 1'b1; start = 1'b1;
    @(negedge clk);  // first clock
    start = 1'b0; addr_reg = ~a; dout_reg = ~d;
    chk(busy == 1'b1, "R9 busy", busy, 1);
    chk(sync_n == 1'b0 && as_o == 1'b0, "R4 clk1 sync/as", {sync_n, as_o}, 0);
    chk(ad_oe == xfer, "R4 clk1 oe", ad_oe, xfer);
    if (xfer) chk(ad_out == a, "R4 clk1 address", ad_out, a);
    chk(in_opn == (k == 2'd1), "R3 in_opn", in_opn, (k == 2'd1));
    chk(m_ion == (k != 2'd3), "R3 m_ion", m_ion, (k != 2'd3));
    chk(rd_wn == !wre, "R3 rd_wn", rd_wn, !wre);
    @(negedge clk);  // second clock
    chk(as_o == xfer, "R4 clk2 as", as_o, xfer);
    if (xfer) chk(ad_out == a && ad_oe, "R4 clk2 address", ad_out, a);
    @(negedge clk);  // third clock
    if (poke) begin start = 1'b1; cyc_kind = 2'd2; end
    chk(sync_n == 1'b1 && as_o == 1'b0, "R5 clk3 sync", {sync_n, as_o}, 2);
    chk(ad_oe == wre, "R6 clk3 oe", ad_oe, wre);
    if (wre) chk(ad_out == d, "R5 clk3 write data", ad_out, d);
    @(negedge clk);  // fourth clock
    start = 1'b0;
    chk(ds_n == !xfer && dd_n == 1'b1, "R5 clk4 ds/dd", {ds_n, dd_n}, {!xfer, 1'b1});
    if (!xfer) chk(m_ion == 1'b1 && ad_oe == 1'b0, "R2 internal quiet", {m_ion, ad_oe}, 2);
    @(negedge clk);  // fifth clock
    chk(ds_n == !xfer, "R6 clk5 ds", ds_n, !xfer);
    chk(dd_n == !rd, "R6 clk5 dd", dd_n, !rd);
    if (xfer) rdy_n = (waits > 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk(ds_n == 1'b0 && busy, "R7 stretched", {ds_n, busy}, 1);
      if (i == waits - 1) rdy_n = 1'b0;
    end
    do @(negedge clk); while (!cyc_done && !ended);
    rdy_n = 1'b1;
    chk(ds_n && dd_n && !ad_oe && !sync_n, "R6 release", {ds_n, dd_n, ad_oe, sync_n}, 4'b1100);
    @(negedge clk);
    chk(cyc_done == 1'b0, "R9 done one clock", cyc_done, 0);
    chk(busy == 1'b0, "R10 no queued cycle", busy, 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sync_n == 0 && as_o == 0 && ds_n && dd_n && !ad_oe, "R1 strobes",
        {sync_n, as_o, ds_n, dd_n, ad_oe}, 5'b00110);
    chk(rd_wn && !in_opn && m_ion && !busy && !cyc_done && din_reg == 0,
        "R1 type/status", {rd_wn, in_opn, m_ion, busy, cyc_done}, 5'b10100);
    // R2 internal, short and long, ready held high
    run_cycle(2'd0, 1'b0, 1'b0, 16'h1111, 16'h2222, 16'h3333, 0, 0);
    run_cycle(2'd0, 1'b1, 1'b1, 16'h1111, 16'h2222, 16'h3334, 0, 0);
    // R3/R6/R8 fetch reads
    run_cycle(2'd1, 1'b0, 1'b0, 16'h0100, 16'h0000, 16'hA5A5, 0, 0);
    run_cycle(2'd1, 1'b1, 1'b0, 16'h0101, 16'hFFFF, 16'h5A5A, 2, 0);
    // R5 memory write, din must hold
    run_cycle(2'd2, 1'b1, 1'b0, 16'h2000, 16'hBEEF, 16'h0F0F, 0, 0);
    run_cycle(2'd2, 1'b1, 1'b0, 16'h2001, 16'hCAFE, 16'h0F0E, 3, 0);
    // memory read with waits
    run_cycle(2'd2, 1'b0, 1'b0, 16'h2002, 16'h0000, 16'h1234, 4, 0);
    // I/O write and read
    run_cycle(2'd3, 1'b1, 1'b0, 16'h00F0, 16'h4321, 16'h9999, 1, 0);
    run_cycle(2'd3, 1'b0, 1'b0, 16'h00F1, 16'h0000, 16'hFEDC, 0, 0);
    // R10 start pulsed mid-cycle
    run_cycle(2'd2, 1'b0, 1'b0, 16'h3000, 16'h0000, 16'h7777, 1, 1);
    repeat (3) @(negedge clk);
    chk(busy == 0 && sync_n == 0, "R10 stays idle", {busy, sync_n}, 0);
    chk(sb.size() == 0, "R9 all cycles completed", sb.size(), 0);
    finish_up();
  end

endmodule